// File: doc/BRIEF.md
# Interrupt Stacking and Vector Sequencer

This block sits beside a small 8-bit CPU core. It saves processor state to a 32-byte stack window and restores it, and it fetches program-counter vectors. The core hands it one of four stack commands: subroutine call, subroutine return, interrupt return, or stack-pointer reset. It also raises interrupt requests on four lines: reset, software interrupt, external interrupt, and timer or second external interrupt. The sequencer walks a byte-wide memory port one byte per cycle. When it has finished, it presents the restored register values and the new program counter.

The stack pointer is 12 bits wide. Its upper seven bits are fixed at 0000011, so only a 5-bit field moves, and the stack always lies in 0x060..0x07F. A hardware or software interrupt pushes a five-byte frame and then reads a two-byte vector. A call pushes only the program counter. Requests that are blocked by the CPU mask bit stay pending until the bit clears.

States are `ST_IDLE`, `ST_PUSH`, `ST_PULL`, `ST_VEC_HI`, `ST_VEC_LO` and `ST_DONE`. The transitions are as follows:
- `ST_IDLE` moves to `ST_VEC_HI` on a reset request.
- `ST_IDLE` moves to `ST_PUSH` on a call or an interrupt.
- `ST_IDLE` moves to `ST_PULL` on either return.
- `ST_IDLE` moves to `ST_DONE` on a stack-pointer reset.
- `ST_PUSH` moves to `ST_VEC_HI` after the last byte of an interrupt frame.
- `ST_PUSH` moves to `ST_DONE` after the last byte of a call frame.
- `ST_PULL` moves to `ST_DONE` after its last byte.
- `ST_VEC_HI` always moves to `ST_VEC_LO`.
- `ST_VEC_LO` always moves to `ST_DONE`.
- `ST_DONE` always moves to `ST_IDLE`.

Top module: `irq_stack_seq`

## Requirements
- R1: The stack pointer output always reads 0x060..0x07F. Its 5-bit field wraps modulo 32 with no overflow flag, so the byte after 0x060 is written at 0x07F.
- R2: Deassertion of `rst_n` leaves the stack pointer at 0x07F. The stack-pointer reset command (`cmd`=3) does the same and finishes in one cycle.
- R3: A push writes at the current stack-pointer address and then decrements the pointer. A pull increments the pointer and then reads at the new address.
- R4: A hardware or software interrupt writes five bytes at descending addresses in this order: PC low, PC high, X, A, CC.
- R5: A stacked PC-high byte holds PC[11:8] in bits 3:0 with bits 7:4 set to one. A stacked CC byte holds CC in bits 4:0 with bits 7:5 set to one.
- R6: The interrupt return command (`cmd`=2) reads CC, A, X, PC high and PC low, in that order, and presents them on the restored outputs.
- R7: The call command (`cmd`=0) writes only PC low and then PC high. The subroutine return command (`cmd`=1) reads PC high and then PC low.
- R8: Vectors are a high byte followed by a low byte. Only bits 3:0 of the high byte are used. The vector pairs start at 0xFF8 for timer, 0xFFA for external, 0xFFC for software interrupt and 0xFFE for reset.
- R9: While `mask_i` is high, external and timer requests stay pending and cause no memory write. They are served once `mask_i` falls. The software interrupt is not blocked.
- R10: Pending work is taken in this order: reset request, then a command on `cmd_valid`, then software interrupt, then external, then timer.
- R11: `mask_set` pulses for one cycle in the cycle after the last stacked byte of an interrupt, which is the cycle of the high vector read.
- R12: A reset request stacks nothing, returns the pointer to 0x07F and loads the vector at 0xFFE.
- R13: `done` rises a fixed number of cycles after the accepting clock edge (1 for the stack-pointer reset, 3 for a call, 3 for a subroutine return, 6 for an interrupt return, 8 for an interrupt, 3 for a reset request). It stays high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_req | input | 1 | Reset interrupt request pulse |
| swi_req | input | 1 | Software interrupt request pulse |
| ext_req | input | 1 | External interrupt request pulse |
| tmr_req | input | 1 | Timer / second external interrupt request pulse |
| mask_i | input | 1 | CPU interrupt mask bit |
| cmd_valid | input | 1 | Stack command strobe, taken when idle |
| cmd | input | 2 | 0 call, 1 subroutine return, 2 interrupt return, 3 stack-pointer reset |
| pc_in | input | 12 | Program counter to stack |
| a_in | input | 8 | Accumulator to stack |
| x_in | input | 8 | Index register to stack |
| cc_in | input | 5 | Condition code to stack |
| mem_addr | output | 12 | Memory byte address |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, same cycle as address |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| mask_set | output | 1 | Request to set the CPU mask bit |
| sp_out | output | 12 | Current stack pointer |
| pc_out | output | 12 | Restored or vectored program counter |
| a_out | output | 8 | Restored accumulator |
| x_out | output | 8 | Restored index register |
| cc_out | output | 5 | Restored condition code |

## Verification
The bench counts falling edges from the negedge on which it drives a stimulus until it sees `done`. The count must be 1 for the pointer reset, 3 for a call or subroutine return, 6 for an interrupt return and 9 for an interrupt request pulse, because the request is latched one edge before it is accepted. The count is 8 when a held request is released by clearing the mask. All outputs are sampled on that same falling edge, after the final register update. Memory writes and the `mask_set` pulse are logged by clock tick, so the bench can check the order of the bytes and the cycle of the pulse exactly.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    typedef enum logic [1:0] {
        OP_CALL = 2'd0,
        OP_RTS  = 2'd1,
        OP_RTI  = 2'd2,
        OP_RSP  = 2'd3
    } seq_op_e;

    // Numeric value doubles as the vector slot offset from the vector base.
    typedef enum logic [1:0] {
        SRC_TMR = 2'd0,
        SRC_EXT = 2'd1,
        SRC_SWI = 2'd2,
        SRC_RST = 2'd3
    } irq_src_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH,
        ST_PULL,
        ST_VEC_HI,
        ST_VEC_LO,
        ST_DONE
    } seq_state_e;

    localparam int NUM_SRC   = 4;
    localparam int IRQ_FRAME = 5;
    localparam int SUB_FRAME = 2;
    localparam int IDX_W     = 3;

endpackage

// File: rtl/irq_sp_unit.sv
module irq_sp_unit #(
    parameter int SP_W   = 5,
    parameter int ADDR_W = 12,
    parameter logic [ADDR_W-SP_W-1:0] PAGE = 7'h03
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_top,
    input  logic              push,
    input  logic              pull,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] up_addr
);
    logic [SP_W-1:0] ptr;
    logic [SP_W-1:0] ptr_up;

    assign ptr_up   = ptr + SP_W'(1);
    assign cur_addr = {PAGE, ptr};
    assign up_addr  = {PAGE, ptr_up};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '1;
        end else if (load_top) begin
            ptr <= '1;
        end else if (push) begin
            ptr <= ptr - SP_W'(1);
        end else if (pull) begin
            ptr <= ptr_up;
        end
    end
endmodule

// File: rtl/irq_req_arbiter.sv
module irq_req_arbiter #(
    parameter int N     = 4,
    parameter int SEL_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req,
    input  logic [N-1:0]     maskable,
    input  logic             mask,
    input  logic [N-1:0]     clr,
    output logic [N-1:0]     pend,
    output logic             valid,
    output logic [SEL_W-1:0] sel
);
    logic [N-1:0] elig;

    for (genvar g = 0; g < N; g++) begin : g_pend
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend[g] <= 1'b0;
            end else begin
                pend[g] <= (pend[g] & ~clr[g]) | req[g];
            end
        end
    end

    assign elig  = pend & ~(maskable & {N{mask}});
    assign valid = |elig;

    // Highest index wins.
    always_comb begin
        sel = '0;
        for (int i = 0; i < N; i++) begin
            if (elig[i]) begin
                sel = SEL_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_frame_mux.sv
module irq_frame_mux #(
    parameter int PC_W   = 12,
    parameter int DATA_W = 8,
    parameter int CC_W   = 5
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] x,
    input  logic [CC_W-1:0]   cc,
    input  logic [2:0]        idx,
    output logic [DATA_W-1:0] byte_o
);
    localparam int HI_W = PC_W - DATA_W;

    always_comb begin
        unique case (idx)
            3'd0:    byte_o = pc[DATA_W-1:0];
            3'd1:    byte_o = {{(DATA_W-HI_W){1'b1}}, pc[PC_W-1:DATA_W]};
            3'd2:    byte_o = x;
            3'd3:    byte_o = a;
            default: byte_o = {{(DATA_W-CC_W){1'b1}}, cc};
        endcase
    end
endmodule

// File: rtl/irq_stack_seq.sv
module irq_stack_seq
    import irq_seq_pkg::*;
#(
    parameter int PC_W   = 12,
    parameter int DATA_W = 8,
    parameter int CC_W   = 5,
    parameter int SP_W   = 5,
    parameter logic [PC_W-SP_W-1:0] SP_PAGE = 7'h03,
    parameter logic [PC_W-1:0] VEC_BASE = 12'hFF8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_req,
    input  logic              swi_req,
    input  logic              ext_req,
    input  logic              tmr_req,
    input  logic              mask_i,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] x_in,
    input  logic [CC_W-1:0]   cc_in,
    output logic [PC_W-1:0]   mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              mask_set,
    output logic [PC_W-1:0]   sp_out,
    output logic [PC_W-1:0]   pc_out,
    output logic [DATA_W-1:0] a_out,
    output logic [DATA_W-1:0] x_out,
    output logic [CC_W-1:0]   cc_out
);
    localparam int HI_W  = PC_W - DATA_W;
    localparam int SEL_W = $clog2(NUM_SRC);

    seq_state_e state, nxt;
    logic [IDX_W-1:0] idx, last;
    logic             is_irq;
    irq_src_e         src_q;
    logic [PC_W-1:0]   pc_s;
    logic [DATA_W-1:0] a_s, x_s;
    logic [CC_W-1:0]   cc_s;

    logic [NUM_SRC-1:0] req_v, pend, clr;
    logic               arb_valid;
    logic [SEL_W-1:0]   arb_sel;
    logic               take_rst, take_cmd, take_irq;
    seq_op_e            op;
    logic [PC_W-1:0]    cur_addr, up_addr, vec_addr;
    logic [DATA_W-1:0]  frame_byte;

    assign op    = seq_op_e'(cmd);
    assign req_v = {rst_req, swi_req, ext_req, tmr_req};

    irq_req_arbiter #(.N(NUM_SRC)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req_v),
        .maskable (4'b0011),
        .mask     (mask_i),
        .clr      (clr),
        .pend     (pend),
        .valid    (arb_valid),
        .sel      (arb_sel)
    );

    assign take_rst = (state == ST_IDLE) && arb_valid && (irq_src_e'(arb_sel) == SRC_RST);
    assign take_cmd = (state == ST_IDLE) && !take_rst && cmd_valid;
    assign take_irq = (state == ST_IDLE) && !take_rst && !cmd_valid && arb_valid;

    always_comb begin
        clr = '0;
        if (take_rst) clr[SRC_RST] = 1'b1;
        if (take_irq) clr[arb_sel] = 1'b1;
    end

    irq_sp_unit #(.SP_W(SP_W), .ADDR_W(PC_W), .PAGE(SP_PAGE)) u_sp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_top (take_rst || (take_cmd && op == OP_RSP)),
        .push     (state == ST_PUSH),
        .pull     (state == ST_PULL),
        .cur_addr (cur_addr),
        .up_addr  (up_addr)
    );

    irq_frame_mux #(.PC_W(PC_W), .DATA_W(DATA_W), .CC_W(CC_W)) u_mux (
        .pc     (pc_s),
        .a      (a_s),
        .x      (x_s),
        .cc     (cc_s),
        .idx    (idx),
        .byte_o (frame_byte)
    );

    assign vec_addr = VEC_BASE + PC_W'({src_q, 1'b0});
    assign sp_out   = cur_addr;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (take_rst) begin
                    nxt = ST_VEC_HI;
                end else if (take_cmd) begin
                    unique case (op)
                        OP_CALL:        nxt = ST_PUSH;
                        OP_RTS, OP_RTI: nxt = ST_PULL;
                        default:        nxt = ST_DONE;
                    endcase
                end else if (take_irq) begin
                    nxt = ST_PUSH;
                end
            end
            ST_PUSH:   if (idx == last) nxt = is_irq ? ST_VEC_HI : ST_DONE;
            ST_PULL:   if (idx == '0) nxt = ST_DONE;
            ST_VEC_HI: nxt = ST_VEC_LO;
            ST_VEC_LO: nxt = ST_DONE;
            ST_DONE:   nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx    <= '0;
            last   <= '0;
            is_irq <= 1'b0;
            src_q  <= SRC_RST;
            pc_s   <= '0;
            a_s    <= '0;
            x_s    <= '0;
            cc_s   <= '0;
            pc_out <= '0;
            a_out  <= '0;
            x_out  <= '0;
            cc_out <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (take_rst) begin
                        src_q  <= SRC_RST;
                        is_irq <= 1'b1;
                    end else if (take_cmd) begin
                        is_irq <= 1'b0;
                        pc_s   <= pc_in;
                        a_s    <= a_in;
                        x_s    <= x_in;
                        cc_s   <= cc_in;
                        unique case (op)
                            OP_CALL: begin idx <= '0; last <= IDX_W'(SUB_FRAME - 1); end
                            OP_RTS:  idx <= IDX_W'(SUB_FRAME - 1);
                            OP_RTI:  idx <= IDX_W'(IRQ_FRAME - 1);
                            default: ;
                        endcase
                    end else if (take_irq) begin
                        idx    <= '0;
                        last   <= IDX_W'(IRQ_FRAME - 1);
                        is_irq <= 1'b1;
                        src_q  <= irq_src_e'(arb_sel);
                        pc_s   <= pc_in;
                        a_s    <= a_in;
                        x_s    <= x_in;
                        cc_s   <= cc_in;
                    end
                end
                ST_PUSH: idx <= idx + IDX_W'(1);
                ST_PULL: begin
                    idx <= idx - IDX_W'(1);
                    unique case (idx)
                        3'd4:    cc_out <= mem_rdata[CC_W-1:0];
                        3'd3:    a_out  <= mem_rdata;
                        3'd2:    x_out  <= mem_rdata;
                        3'd1:    pc_out[PC_W-1:DATA_W] <= mem_rdata[HI_W-1:0];
                        default: pc_out[DATA_W-1:0]    <= mem_rdata;
                    endcase
                end
                ST_VEC_HI: pc_out[PC_W-1:DATA_W] <= mem_rdata[HI_W-1:0];
                ST_VEC_LO: pc_out[DATA_W-1:0]    <= mem_rdata;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        mem_we    = 1'b0;
        mem_wdata = '0;
        mem_addr  = '0;
        mask_set  = 1'b0;
        unique case (state)
            ST_PUSH: begin
                mem_we    = 1'b1;
                mem_wdata = frame_byte;
                mem_addr  = cur_addr;
            end
            ST_PULL:   mem_addr = up_addr;
            ST_VEC_HI: begin
                mem_addr = vec_addr;
                mask_set = 1'b1;
            end
            ST_VEC_LO: mem_addr = vec_addr + PC_W'(1);
            default: ;
        endcase
    end

    assign busy = (state != ST_IDLE);
    assign done = (state == ST_DONE);

endmodule

// File: rtl/irq_seq_checker.sv
module irq_seq_checker #(
    parameter logic [6:0] PAGE = 7'h03
) (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_we,
    input logic [11:0] mem_addr,
    input logic [11:0] sp_out,
    input logic        mask_set,
    input logic        done,
    input logic        busy
);
    // R1: every stack write lands inside the fixed page
    a_r1_write_in_page: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_addr[11:5] == PAGE);

    // R3: a push writes at the current pointer
    a_r3_push_at_sp: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_addr == sp_out);

    // R3: the pointer drops by one after each push (modulo the 5-bit field)
    a_r3_push_dec: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> sp_out[4:0] == $past(sp_out[4:0]) - 5'd1);

    // R8: the mask pulse comes with a read of a vector high byte
    a_r8_vec_area: assert property (@(posedge clk) disable iff (!rst_n)
        mask_set |-> (mem_addr[11:3] == 9'h1FF) && !mem_addr[0] && !mem_we);

    // R11: the low vector byte follows the high one directly
    a_r11_vec_lo_next: assert property (@(posedge clk) disable iff (!rst_n)
        mask_set |=> mem_addr == $past(mem_addr) + 12'd1);

    // R13: completion is a single-cycle pulse
    a_r13_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: nothing is written while the sequencer is idle
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_we);
endmodule

bind irq_stack_seq irq_seq_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .sp_out   (sp_out),
    .mask_set (mask_set),
    .done     (done),
    .busy     (busy)
);

// File: tb/irq_stack_seq_bench.sv
module irq_stack_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rst_req = 0, swi_req = 0, ext_req = 0, tmr_req = 0;
    logic        mask_i = 0;
    logic        cmd_valid = 0;
    logic [1:0]  cmd = 0;
    logic [11:0] pc_in = 0;
    logic [7:0]  a_in = 0, x_in = 0;
    logic [4:0]  cc_in = 0;
    logic [11:0] mem_addr;
    logic        mem_we;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    logic        busy, done, mask_set;
    logic [11:0] sp_out, pc_out;
    logic [7:0]  a_out, x_out;
    logic [4:0]  cc_out;

    always #4 clk = ~clk;

    irq_stack_seq u_irq_stack_seq (
        .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .swi_req(swi_req),
        .ext_req(ext_req), .tmr_req(tmr_req), .mask_i(mask_i),
        .cmd_valid(cmd_valid), .cmd(cmd), .pc_in(pc_in), .a_in(a_in),
        .x_in(x_in), .cc_in(cc_in), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy),
        .done(done), .mask_set(mask_set), .sp_out(sp_out), .pc_out(pc_out),
        .a_out(a_out), .x_out(x_out), .cc_out(cc_out)
    );

    // Memory model: 32-byte stack page and 8 vector bytes
    logic [7:0] stk [32];
    logic [7:0] vec [8];
    assign mem_rdata = (mem_addr[11:5] == 7'h03) ? stk[mem_addr[4:0]] :
                       (mem_addr[11:3] == 9'h1FF) ? vec[mem_addr[2:0]] : 8'h00;

    logic [11:0] lg_a [64];
    logic [7:0]  lg_d [64];
    int nlog = 0, tick = 0, last_wr_tick = 0, mask_tick = 0, mask_cnt = 0;

    always @(posedge clk) begin
        tick <= tick + 1;
        if (mem_we) begin
            stk[mem_addr[4:0]] <= mem_wdata;
            lg_a[nlog % 64] <= mem_addr;
            lg_d[nlog % 64] <= mem_wdata;
            nlog <= nlog + 1;
            last_wr_tick <= tick;
        end
        if (mask_set) begin
            mask_tick <= tick;
            mask_cnt  <= mask_cnt + 1;
        end
    end

    int n_chk = 0, n_fail = 0, lat = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] fbyte(input int k, input logic [11:0] pc,
                                         input logic [7:0] a, input logic [7:0] x,
                                         input logic [4:0] cc);
        case (k)
            0: return pc[7:0];
            1: return {4'hF, pc[11:8]};
            2: return x;
            3: return a;
            default: return {3'b111, cc};
        endcase
    endfunction

    function automatic logic [11:0] vec_pc(input int slot);
        return {vec[2*slot][3:0], vec[2*slot+1]};
    endfunction

    task automatic wait_done();
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
            cmd_valid = 0; rst_req = 0; swi_req = 0; ext_req = 0; tmr_req = 0;
        end while (!done && lat < 60);
    endtask

    task automatic issue(input logic [1:0] c);
        @(negedge clk);
        cmd_valid = 1; cmd = c;
        wait_done();
    endtask

    task automatic pulse(input logic [3:0] m);
        @(negedge clk);
        {rst_req, swi_req, ext_req, tmr_req} = m;
        wait_done();
    endtask

    task automatic check_frame(input int base, input int n, input logic [4:0] sp0,
                               input logic [11:0] pc, input logic [7:0] a,
                               input logic [7:0] x, input logic [4:0] cc, input string tag);
        chk(nlog - base == n, {tag, " byte count"}, nlog - base, n);
        for (int k = 0; k < n; k++) begin
            chk(lg_a[(base + k) % 64] == {7'h03, 5'(sp0 - 5'(k))}, {tag, " addr"},
                lg_a[(base + k) % 64], {7'h03, 5'(sp0 - 5'(k))});
            chk(lg_d[(base + k) % 64] == fbyte(k, pc, a, x, cc), {tag, " data"},
                lg_d[(base + k) % 64], fbyte(k, pc, a, x, cc));
        end
    endtask

    task automatic set_regs(input logic [11:0] pc, input logic [7:0] a,
                            input logic [7:0] x, input logic [4:0] cc);
        pc_in = pc; a_in = a; x_in = x; cc_in = cc;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int base, mc, seed;
        logic [4:0] sp0;
        {vec[0], vec[1]} = {8'hA1, 8'h23};  // timer    -> 0x123
        {vec[2], vec[3]} = {8'hB2, 8'h45};  // external -> 0x245
        {vec[4], vec[5]} = {8'hC3, 8'h67};  // software -> 0x367
        {vec[6], vec[7]} = {8'hD4, 8'h89};  // reset    -> 0x489
        seed = $urandom(32'h5EED_0001);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R2: state after reset
        chk(sp_out == 12'h07F, "R2 reset sp", sp_out, 12'h07F);
        chk(!busy && !done, "R2 reset idle", {busy, done}, 0);

        // R12: reset request
        base = nlog; mc = mask_cnt;
        pulse(4'b1000);
        chk(lat == 4, "R13 reset-request latency", lat, 4);
        chk(pc_out == 12'h489, "R12 R8 reset vector", pc_out, 12'h489);
        chk(nlog == base, "R12 no stacking", nlog - base, 0);
        chk(sp_out == 12'h07F, "R12 sp", sp_out, 12'h07F);
        chk(mask_cnt == mc + 1, "R11 mask on reset", mask_cnt - mc, 1);

        // R4 R5 software interrupt with known values
        set_regs(12'hABC, 8'h5A, 8'hC3, 5'h15);
        base = nlog; mc = mask_cnt;
        pulse(4'b0100);
        chk(lat == 9, "R13 irq latency", lat, 9);
        check_frame(base, 5, 5'h1F, 12'hABC, 8'h5A, 8'hC3, 5'h15, "R4 R5 swi frame");
        chk(pc_out == 12'h367, "R8 swi vector", pc_out, 12'h367);
        chk(sp_out == 12'h07A, "R3 sp after frame", sp_out, 12'h07A);
        chk(mask_cnt == mc + 1 && mask_tick == last_wr_tick + 1, "R11 mask after stacking",
            mask_tick - last_wr_tick, 1);

        // R6 interrupt return
        set_regs(12'h000, 8'h00, 8'h00, 5'h00);
        issue(2'd2);
        chk(lat == 6, "R13 rti latency", lat, 6);
        chk(pc_out == 12'hABC, "R6 pc", pc_out, 12'hABC);
        chk(a_out == 8'h5A, "R6 a", a_out, 8'h5A);
        chk(x_out == 8'hC3, "R6 x", x_out, 8'hC3);
        chk(cc_out == 5'h15, "R6 cc", cc_out, 5'h15);
        chk(sp_out == 12'h07F, "R3 sp after pulls", sp_out, 12'h07F);

        // R7 call and return
        set_regs(12'h5E1, 8'h11, 8'h22, 5'h03);
        base = nlog;
        issue(2'd0);
        chk(lat == 3, "R13 call latency", lat, 3);
        check_frame(base, 2, 5'h1F, 12'h5E1, 8'h11, 8'h22, 5'h03, "R7 call frame");
        chk(sp_out == 12'h07D, "R7 sp after call", sp_out, 12'h07D);
        issue(2'd1);
        chk(lat == 3, "R13 rts latency", lat, 3);
        chk(pc_out == 12'h5E1, "R7 rts pc", pc_out, 12'h5E1);
        chk(sp_out == 12'h07F, "R7 sp after rts", sp_out, 12'h07F);

        // R2 pointer reset command
        issue(2'd0);
        issue(2'd3);
        chk(lat == 1, "R13 rsp latency", lat, 1);
        chk(sp_out == 12'h07F, "R2 rsp", sp_out, 12'h07F);

        // R1 wrap: 16 calls fill all 32 bytes
        for (int i = 0; i < 16; i++) begin
            set_regs(12'(i), 8'h0, 8'h0, 5'h0);
            base = nlog;
            issue(2'd0);
        end
        chk(lg_a[base % 64] == 12'h061 && lg_a[(base + 1) % 64] == 12'h060,
            "R1 last bytes at bottom", lg_a[(base + 1) % 64], 12'h060);
        chk(sp_out == 12'h07F, "R1 wrap to top", sp_out, 12'h07F);
        base = nlog;
        issue(2'd0);
        chk(lg_a[base % 64] == 12'h07F, "R1 write after wrap", lg_a[base % 64], 12'h07F);
        issue(2'd3);

        // R9 masked external request is held
        mask_i = 1;
        base = nlog;
        pulse(4'b0010);
        chk(lat == 60 && !busy, "R9 held while masked", lat, 60);
        chk(nlog == base, "R9 no writes while masked", nlog - base, 0);
        @(negedge clk);
        mask_i = 0;
        wait_done();
        chk(lat == 8, "R9 R13 served after unmask", lat, 8);
        chk(pc_out == 12'h245, "R8 ext vector", pc_out, 12'h245);
        issue(2'd2);

        // R10 priority: swi ignores mask, then ext before tmr
        mask_i = 1;
        pulse(4'b0111);
        chk(lat == 9 && pc_out == 12'h367, "R9 R10 swi first despite mask", pc_out, 12'h367);
        issue(2'd2);
        @(negedge clk);
        mask_i = 0;
        wait_done();
        chk(pc_out == 12'h245, "R10 ext before tmr", pc_out, 12'h245);
        issue(2'd2);
        wait_done();
        chk(lat == 9 && pc_out == 12'h123, "R10 R8 tmr last", pc_out, 12'h123);
        issue(2'd2);

        // R10 reset request ahead of software interrupt
        base = nlog;
        pulse(4'b1100);
        chk(lat == 4 && pc_out == 12'h489, "R10 reset first", pc_out, 12'h489);
        chk(nlog == base, "R10 R12 reset stacks nothing", nlog - base, 0);
        wait_done();
        chk(lat == 9 && pc_out == 12'h367, "R10 swi after reset", pc_out, 12'h367);
        issue(2'd3);

        // Random frames with fixed seed
        for (int it = 0; it < 30; it++) begin
            logic [11:0] rpc;
            logic [7:0]  ra, rx;
            logic [4:0]  rcc;
            rpc = 12'($urandom); ra = 8'($urandom); rx = 8'($urandom); rcc = 5'($urandom);
            sp0 = sp_out[4:0];
            set_regs(rpc, ra, rx, rcc);
            base = nlog;
            if ($urandom % 2 == 0) begin
                pulse(4'b0100);
                check_frame(base, 5, sp0, rpc, ra, rx, rcc, "R4 R5 random frame");
                set_regs(~rpc, ~ra, ~rx, ~rcc);
                issue(2'd2);
                chk(pc_out == rpc && a_out == ra && x_out == rx && cc_out == rcc,
                    "R6 random restore", {pc_out, a_out, x_out}, {rpc, ra, rx});
            end else begin
                issue(2'd0);
                check_frame(base, 2, sp0, rpc, ra, rx, rcc, "R7 random call");
                set_regs(~rpc, ra, rx, rcc);
                issue(2'd1);
                chk(pc_out == rpc, "R7 random return", pc_out, rpc);
            end
            chk(sp_out[4:0] == sp0, "R3 random sp balance", sp_out, {7'h03, sp0});
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule